// File: doc/BRIEF.md
# Dual-Mode General Purpose Timer

This peripheral sits on a simple 32-bit register bus and runs in one of two modes, picked by a configuration register. In down-counter mode a 32-bit count is loaded from an interval register when the enable bit is set. It then decrements once per system clock. When the count reaches zero the block raises a status flag. It can also emit a one-cycle pulse meant to start an ADC conversion. The count either reloads (periodic) or stops and clears its own enable bit (one-shot).

In real-time mode the same enable bit gates a counter that advances on each pulse of a once-per-second tick input. When the counter would pass a programmable match value it wraps to zero, and that wrap raises a second status flag. A level interrupt is the OR of the raw status bits that are allowed by an interrupt mask. Software clears status bits by writing ones to a clear register. Prescaler registers exist as plain storage so that the software layout stays complete.

Top module: `gp_timer_top`

## Requirements
- R1: After reset every mapped register reads 0, and `irq` and `adc_trig` are low.
- R2: The configuration (0x00), both mode registers (0x04, 0x08), control (0x0C) and the four prescale words (0x38, 0x3C, 0x40, 0x44) store and read back all 32 bits written.
- R3: The timer A interval (0x28) and match (0x30) registers hold a low half and a high half. While configuration is below 4, a write stores all 32 bits and a read returns all 32 bits. At 4 or above, only the low half is written and a read returns the low half with zero above it. A write to the timer B register (0x2C or 0x34) puts its low 16 bits into the high half, and a read of the timer B register returns the high half.
- R4: The interrupt mask register (0x18) keeps only the bits set in 0x77.
- R5: With configuration 0, writing control bit 0 from 0 to 1 loads the interval value L. The first timeout comes L+1 clock edges after the write edge, and raw status (0x1C) bit 0 reads 1 from that edge on.
- R6: When mode A bit 0 is 0 (periodic), the count reloads with no lost cycle, so timeouts repeat every L+1 clocks.
- R7: When mode A bit 0 is 1 (one-shot), a timeout clears control bit 0 and no further timeouts follow.
- R8: At each timeout with control bit 5 set, `adc_trig` is high for the one cycle in which raw bit 0 first shows that timeout. With bit 5 clear, `adc_trig` stays low.
- R9: Clearing control bit 0 stops the down-counter, and no further timeouts occur.
- R10: With configuration 1 and control bit 0 set, each `sec_tick` pulse raises the timer A value (0x48) by one. A count that would exceed the match value becomes 0, and reaching 0 sets raw bit 3. Ticks do nothing while control bit 0 is clear. 0x48 reads 0 in any other configuration.
- R11: The masked status register (0x20) reads raw AND mask, and `irq` is high exactly when that value is nonzero. Writing ones to 0x24 clears those raw bits, and 0x24 reads 0. A bit set by hardware in the same cycle as a clear of that bit stays set.
- R12: Unmapped offsets and the timer B value register (0x4C) read 0, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the register access |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for `bus_addr` in the same cycle |
| sec_tick | input | 1 | One-cycle pulse per second for real-time mode |
| irq | output | 1 | Level interrupt: masked status nonzero |
| adc_trig | output | 1 | One-cycle ADC trigger pulse on timeout |

## Verification
Several properties are checked on every cycle. The down-counter must step by exactly one while it runs. The real-time count must either step by one or wrap to zero on a tick, and must hold without one. A one-shot timeout must drop the enable bit. A hardware-set status bit must survive a same-cycle clear. Every trigger pulse must coincide with raw bit 0, and the interrupt may only be high when some raw bit is set. Only the bench scenarios can show the timing from start to first timeout, the exact periods across a sweep of interval values, the wrap points for a sweep of match values, and the half-register rules when the configuration changes. The bench also shows that the RTC status bit can never reach the interrupt, because the mask cannot hold bit 3.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  // Register byte offsets
  localparam logic [31:0] OFF_CFG     = 32'h00;
  localparam logic [31:0] OFF_MODE_A  = 32'h04;
  localparam logic [31:0] OFF_MODE_B  = 32'h08;
  localparam logic [31:0] OFF_CTRL    = 32'h0C;
  localparam logic [31:0] OFF_MASK    = 32'h18;
  localparam logic [31:0] OFF_RAW     = 32'h1C;
  localparam logic [31:0] OFF_MIS     = 32'h20;
  localparam logic [31:0] OFF_CLR     = 32'h24;
  localparam logic [31:0] OFF_LOAD_A  = 32'h28;
  localparam logic [31:0] OFF_LOAD_B  = 32'h2C;
  localparam logic [31:0] OFF_MATCH_A = 32'h30;
  localparam logic [31:0] OFF_MATCH_B = 32'h34;
  localparam logic [31:0] OFF_PRE0    = 32'h38;
  localparam logic [31:0] OFF_VAL_A   = 32'h48;
  localparam logic [31:0] OFF_VAL_B   = 32'h4C;

  // Bit positions
  localparam int CTL_EN       = 0;
  localparam int CTL_TRIG     = 5;
  localparam int MODE_ONESHOT = 0;
  localparam int ST_TIMEOUT   = 0;
  localparam int ST_RTC       = 3;

  localparam logic [31:0] MASK_WRITABLE = 32'h77;
  localparam int unsigned CFG_SPLIT_MIN = 4;

  typedef enum logic [1:0] {
    KIND_DOWN,
    KIND_RTC,
    KIND_RSVD,
    KIND_SPLIT
  } gpt_kind_e;
endpackage

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 32,
  parameter int N_PRE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wen,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              hw_stop,
  input  logic [DW-1:0]     raw_status,
  input  logic [DW-1:0]     rtc_val,
  output gpt_kind_e         kind,
  output logic              en,
  output logic              trig_en,
  output logic              oneshot,
  output logic              start,
  output logic [DW-1:0]     load_val,
  output logic [DW-1:0]     match_val,
  output logic [DW-1:0]     mask,
  output logic              clr_wr,
  output logic [DW-1:0]     clr_val
);
  localparam int HW = DW / 2;

  logic [31:0]   a32;
  logic          wide;
  logic [DW-1:0] cfg_q,  cfg_d;
  logic [DW-1:0] mda_q,  mda_d;
  logic [DW-1:0] mdb_q,  mdb_d;
  logic [DW-1:0] ctl_q,  ctl_d;
  logic [DW-1:0] msk_q,  msk_d;
  logic [HW-1:0] ldl_q,  ldl_d;
  logic [HW-1:0] ldh_q,  ldh_d;
  logic [HW-1:0] mtl_q,  mtl_d;
  logic [HW-1:0] mth_q,  mth_d;
  logic [DW-1:0] pre_vec [N_PRE];

  assign a32  = 32'(addr);
  assign wide = (cfg_q < DW'(CFG_SPLIT_MIN));

  // Next-state for the register bank
  always_comb begin
    cfg_d = cfg_q;
    mda_d = mda_q;
    mdb_d = mdb_q;
    ctl_d = ctl_q;
    msk_d = msk_q;
    ldl_d = ldl_q;
    ldh_d = ldh_q;
    mtl_d = mtl_q;
    mth_d = mth_q;
    if (wen) begin
      case (a32)
        OFF_CFG:    cfg_d = wdata;
        OFF_MODE_A: mda_d = wdata;
        OFF_MODE_B: mdb_d = wdata;
        OFF_CTRL:   ctl_d = wdata;
        OFF_MASK:   msk_d = wdata & DW'(MASK_WRITABLE);
        OFF_LOAD_A: begin
          ldl_d = wdata[HW-1:0];
          if (wide) ldh_d = wdata[DW-1:HW];
        end
        OFF_LOAD_B: ldh_d = wdata[HW-1:0];
        OFF_MATCH_A: begin
          mtl_d = wdata[HW-1:0];
          if (wide) mth_d = wdata[DW-1:HW];
        end
        OFF_MATCH_B: mth_d = wdata[HW-1:0];
        default: ;
      endcase
    end
    // one-shot completion drops the enable unless software writes control now
    if (hw_stop && !(wen && a32 == OFF_CTRL)) ctl_d[CTL_EN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      mda_q <= '0;
      mdb_q <= '0;
      ctl_q <= '0;
      msk_q <= '0;
      ldl_q <= '0;
      ldh_q <= '0;
      mtl_q <= '0;
      mth_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      mda_q <= mda_d;
      mdb_q <= mdb_d;
      ctl_q <= ctl_d;
      msk_q <= msk_d;
      ldl_q <= ldl_d;
      ldh_q <= ldh_d;
      mtl_q <= mtl_d;
      mth_q <= mth_d;
    end
  end

  // Prescale words: storage only
  for (genvar gi = 0; gi < N_PRE; gi++) begin : g_pre
    logic [DW-1:0] pre_q;
    logic          pre_we;
    assign pre_we = wen && (a32 == OFF_PRE0 + 32'(4 * gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre_q <= '0;
      else if (pre_we) pre_q <= wdata;
    end
    assign pre_vec[gi] = pre_q;
  end

  // Mode decode
  always_comb begin
    if (cfg_q == '0)          kind = KIND_DOWN;
    else if (cfg_q == DW'(1)) kind = KIND_RTC;
    else if (!wide)           kind = KIND_SPLIT;
    else                      kind = KIND_RSVD;
  end

  assign en        = ctl_q[CTL_EN];
  assign trig_en   = ctl_q[CTL_TRIG];
  assign oneshot   = mda_q[MODE_ONESHOT];
  assign start     = wen && (a32 == OFF_CTRL) && wdata[CTL_EN] && !ctl_q[CTL_EN];
  assign load_val  = {ldh_q, ldl_q};
  assign match_val = {mth_q, mtl_q};
  assign mask      = msk_q;
  assign clr_wr    = wen && (a32 == OFF_CLR);
  assign clr_val   = wdata;

  // Read mux
  always_comb begin
    rdata = '0;
    case (a32)
      OFF_CFG:     rdata = cfg_q;
      OFF_MODE_A:  rdata = mda_q;
      OFF_MODE_B:  rdata = mdb_q;
      OFF_CTRL:    rdata = ctl_q;
      OFF_MASK:    rdata = msk_q;
      OFF_RAW:     rdata = raw_status;
      OFF_MIS:     rdata = raw_status & msk_q;
      OFF_CLR:     rdata = '0;
      OFF_LOAD_A:  rdata = {(wide ? ldh_q : {HW{1'b0}}), ldl_q};
      OFF_LOAD_B:  rdata = {{HW{1'b0}}, ldh_q};
      OFF_MATCH_A: rdata = {(wide ? mth_q : {HW{1'b0}}), mtl_q};
      OFF_MATCH_B: rdata = {{HW{1'b0}}, mth_q};
      OFF_VAL_A:   rdata = (kind == KIND_RTC) ? rtc_val : '0;
      OFF_VAL_B:   rdata = '0;
      default:     rdata = '0;
    endcase
    for (int i = 0; i < N_PRE; i++) begin
      if (a32 == OFF_PRE0 + 32'(4 * i)) rdata = pre_vec[i];
    end
  end

  // R7
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_stop && !(wen && a32 == OFF_CTRL)) |=> !ctl_q[CTL_EN]);

  // R4
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && a32 == OFF_MASK) |=> ((msk_q & ~DW'(MASK_WRITABLE)) == '0));
endmodule

// File: rtl/gpt_count.sv
module gpt_count
  import gpt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  gpt_kind_e     kind,
  input  logic          en,
  input  logic          trig_en,
  input  logic          oneshot,
  input  logic          start,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] match_val,
  input  logic          sec_tick,
  output logic          timeout,
  output logic          hw_stop,
  output logic          rtc_wrap,
  output logic [DW-1:0] rtc_val,
  output logic          trig
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rtc_q, rtc_d, rtc_inc;
  logic          trig_q, trig_d;
  logic          run_down;
  logic          rtc_step;

  // Down-counter
  assign run_down = (kind == KIND_DOWN) && en && !start;
  assign timeout  = run_down && (cnt_q == '0);
  assign hw_stop  = timeout && oneshot;

  always_comb begin
    cnt_d = cnt_q;
    if (start)         cnt_d = load_val;
    else if (timeout)  cnt_d = load_val;
    else if (run_down) cnt_d = cnt_q - DW'(1);
  end

  // Real-time counter
  assign rtc_step = (kind == KIND_RTC) && en && sec_tick;
  assign rtc_inc  = rtc_q + DW'(1);

  always_comb begin
    rtc_d = rtc_q;
    if (rtc_step) rtc_d = (rtc_inc > match_val) ? '0 : rtc_inc;
  end

  assign rtc_wrap = rtc_step && (rtc_d == '0);
  assign trig_d   = timeout && trig_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rtc_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rtc_q  <= rtc_d;
      trig_q <= trig_d;
    end
  end

  assign rtc_val = rtc_q;
  assign trig    = trig_q;

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_down && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - DW'(1)));

  // R10
  rtc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_step |=> (rtc_q == '0 || rtc_q == $past(rtc_q) + DW'(1)));

  // R10
  rtc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rtc_step |=> $stable(rtc_q));
endmodule

// File: rtl/gpt_status.sv
module gpt_status #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic          clr_wr,
  input  logic [DW-1:0] clr_val,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] raw,
  output logic          irq
);
  logic [DW-1:0] raw_q, raw_d, clr_eff;

  assign clr_eff = clr_wr ? clr_val : '0;

  always_comb begin
    raw_d = (raw_q & ~clr_eff) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw = raw_q;
  assign irq = |(raw_q & mask);

  // R11
  hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_q != '0));
endmodule

// File: rtl/gp_timer_top.sv
module gp_timer_top
  import gpt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 32,
  parameter int N_PRE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              sec_tick,
  output logic              irq,
  output logic              adc_trig
);
  gpt_kind_e     kind;
  logic          en, trig_en, oneshot, start;
  logic [DW-1:0] load_val, match_val, mask;
  logic          clr_wr;
  logic [DW-1:0] clr_val;
  logic          timeout, hw_stop, rtc_wrap;
  logic [DW-1:0] rtc_val, raw, set_vec;

  gpt_regs #(.ADDR_W(ADDR_W), .DW(DW), .N_PRE(N_PRE)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wen(bus_wen), .wdata(bus_wdata),
    .rdata(bus_rdata), .hw_stop(hw_stop), .raw_status(raw), .rtc_val(rtc_val),
    .kind(kind), .en(en), .trig_en(trig_en), .oneshot(oneshot), .start(start),
    .load_val(load_val), .match_val(match_val), .mask(mask),
    .clr_wr(clr_wr), .clr_val(clr_val)
  );

  gpt_count #(.DW(DW)) u_count (
    .clk(clk), .rst_n(rst_n), .kind(kind), .en(en), .trig_en(trig_en),
    .oneshot(oneshot), .start(start), .load_val(load_val), .match_val(match_val),
    .sec_tick(sec_tick), .timeout(timeout), .hw_stop(hw_stop),
    .rtc_wrap(rtc_wrap), .rtc_val(rtc_val), .trig(adc_trig)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[ST_TIMEOUT] = timeout;
    set_vec[ST_RTC]     = rtc_wrap;
  end

  gpt_status #(.DW(DW)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_wr(clr_wr),
    .clr_val(clr_val), .mask(mask), .raw(raw), .irq(irq)
  );

  // R8
  trig_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> raw[ST_TIMEOUT]);
endmodule

// File: tb/gp_timer_top_tb_top.sv
module gp_timer_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wen;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        sec_tick;
  logic        irq;
  logic        adc_trig;

  int total = 0;
  int bad   = 0;

  gp_timer_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_tick(sec_tick),
    .irq(irq), .adc_trig(adc_trig)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int pulses;
    int rtc_m;
    rst_n = 1'b0; bus_addr = '0; bus_wen = 1'b0; bus_wdata = '0; sec_tick = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state over the whole map
    for (int a = 0; a <= 'h4C; a += 4) begin
      @(negedge clk);
      rd(8'(a), v); chk("R1 reset read", v, 32'h0);
    end
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 adc_trig", {31'b0, adc_trig}, 32'h0);

    // R2: storage registers
    wr(8'h04, 32'hA5A5_0F0E); wr(8'h08, 32'hDEAD_BEEF); wr(8'h0C, 32'h0000_0F00);
    for (int i = 0; i < 4; i++) wr(8'(8'h38 + 4 * i), 32'h1111_0000 * (i + 1) + i);
    rd(8'h04, v); chk("R2 mode A", v, 32'hA5A5_0F0E);
    rd(8'h08, v); chk("R2 mode B", v, 32'hDEAD_BEEF);
    rd(8'h0C, v); chk("R2 control", v, 32'h0000_0F00);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rd(8'(8'h38 + 4 * i), v); chk("R2 prescale", v, 32'h1111_0000 * (i + 1) + i);
    end
    wr(8'h00, 32'h7654_3210); rd(8'h00, v); chk("R2 config", v, 32'h7654_3210);
    wr(8'h00, 32'h0); wr(8'h04, 32'h0); wr(8'h0C, 32'h0);

    // R3: interval and match halves
    wr(8'h28, 32'h1234_5678);
    rd(8'h28, v); chk("R3 load A wide", v, 32'h1234_5678);
    rd(8'h2C, v); chk("R3 load B high", v, 32'h0000_1234);
    wr(8'h2C, 32'h9999_ABCD);
    rd(8'h28, v); chk("R3 load A after B", v, 32'hABCD_5678);
    wr(8'h30, 32'h0BAD_F00D); wr(8'h34, 32'h0000_0042);
    rd(8'h30, v); chk("R3 match A", v, 32'h0042_F00D);
    rd(8'h34, v); chk("R3 match B", v, 32'h0000_0042);
    wr(8'h00, 32'h4);
    wr(8'h28, 32'hAAAA_5555);
    rd(8'h28, v); chk("R3 load A split", v, 32'h0000_5555);
    rd(8'h2C, v); chk("R3 high kept", v, 32'h0000_ABCD);
    wr(8'h00, 32'h0);
    rd(8'h28, v); chk("R3 load A rewide", v, 32'hABCD_5555);

    // R4: mask writability
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, v); chk("R4 mask", v, 32'h0000_0077);
    wr(8'h18, 32'h0);

    // R5 R6 R8: periodic sweep of interval values
    for (int L = 0; L < 8; L++) begin
      wr(8'h28, 32'(L));
      wr(8'h24, 32'hFFFF_FFFF);
      wr(8'h0C, 32'h21);
      pulses = 0;
      for (int c = 1; c <= 24; c++) begin
        @(posedge clk); @(negedge clk);
        if (adc_trig) pulses++;
        if (c == L) begin rd(8'h1C, v); chk("R5 before first timeout", v & 32'h1, 32'h0); end
        if (c == L + 1) begin rd(8'h1C, v); chk("R5 first timeout", v & 32'h1, 32'h1); end
      end
      chk("R6 R8 pulse count", 32'(pulses), 32'(24 / (L + 1)));
      wr(8'h0C, 32'h0);
    end

    // R7: one-shot
    wr(8'h04, 32'h1);
    for (int L = 0; L < 9; L += 3) begin
      wr(8'h28, 32'(L));
      wr(8'h24, 32'hFFFF_FFFF);
      wr(8'h0C, 32'h21);
      pulses = 0;
      for (int c = 1; c <= 24; c++) begin
        @(posedge clk); @(negedge clk);
        if (adc_trig) pulses++;
      end
      chk("R7 single timeout", 32'(pulses), 32'h1);
      rd(8'h0C, v); chk("R7 enable cleared", v, 32'h20);
      wr(8'h0C, 32'h0);
    end
    wr(8'h04, 32'h0);

    // R8: trigger disabled
    wr(8'h28, 32'h2); wr(8'h24, 32'hFFFF_FFFF); wr(8'h0C, 32'h01);
    pulses = 0;
    for (int c = 1; c <= 12; c++) begin
      @(posedge clk); @(negedge clk);
      if (adc_trig) pulses++;
    end
    chk("R8 no trigger", 32'(pulses), 32'h0);
    rd(8'h1C, v); chk("R8 raw still set", v & 32'h1, 32'h1);
    wr(8'h0C, 32'h0);

    // R9: stop before timeout
    wr(8'h28, 32'd10); wr(8'h24, 32'hFFFF_FFFF); wr(8'h0C, 32'h21);
    repeat (3) begin @(posedge clk); @(negedge clk); end
    wr(8'h0C, 32'h0); wr(8'h24, 32'hFFFF_FFFF);
    pulses = 0;
    for (int c = 1; c <= 30; c++) begin
      @(posedge clk); @(negedge clk);
      if (adc_trig) pulses++;
    end
    chk("R9 stopped pulses", 32'(pulses), 32'h0);
    rd(8'h1C, v); chk("R9 stopped raw", v, 32'h0);

    // R11: masked status, clear, hardware wins
    wr(8'h18, 32'h1); wr(8'h28, 32'h0); wr(8'h0C, 32'h01);
    wr(8'h24, 32'h1);
    rd(8'h1C, v); chk("R11 set beats clear", v & 32'h1, 32'h1);
    rd(8'h20, v); chk("R11 masked", v, 32'h1);
    chk("R11 irq high", {31'b0, irq}, 32'h1);
    rd(8'h24, v); chk("R11 clear reads zero", v, 32'h0);
    wr(8'h0C, 32'h0); wr(8'h24, 32'h1);
    rd(8'h1C, v); chk("R11 cleared", v, 32'h0);
    chk("R11 irq low", {31'b0, irq}, 32'h0);

    // R10: real-time counter sweep over match values
    wr(8'h00, 32'h1); wr(8'h18, 32'hFF); wr(8'h0C, 32'h01);
    rd(8'h48, v); rtc_m = int'(v);
    for (int M = 0; M < 4; M++) begin
      wr(8'h30, 32'(M));
      for (int t = 0; t < 8; t++) begin
        wr(8'h24, 32'hFFFF_FFFF);
        tick();
        rtc_m = (rtc_m + 1 > M) ? 0 : rtc_m + 1;
        rd(8'h48, v); chk("R10 rtc value", v, 32'(rtc_m));
        rd(8'h1C, v); chk("R10 wrap flag", v, (rtc_m == 0) ? 32'h8 : 32'h0);
        chk("R11 rtc flag masked off", {31'b0, irq}, 32'h0);
      end
    end
    wr(8'h0C, 32'h0);
    tick();
    rd(8'h48, v); chk("R10 tick ignored when disabled", v, 32'(rtc_m));
    wr(8'h00, 32'h0);
    rd(8'h48, v); chk("R10 value zero in counter mode", v, 32'h0);

    // R12: unmapped offsets
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R12 unmapped 0x10", v, 32'h0);
    rd(8'h14, v); chk("R12 unmapped 0x14", v, 32'h0);
    rd(8'h50, v); chk("R12 unmapped 0x50", v, 32'h0);
    rd(8'h4C, v); chk("R12 value B", v, 32'h0);
    rd(8'h00, v); chk("R12 config untouched", v, 32'h0);
    rd(8'h0C, v); chk("R12 control untouched", v, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule